// File: doc/BRIEF.md
# UART 16x Sampling-Tick Generator

This block turns a fast reference clock into a single-cycle enable that pulses at sixteen times a serial port's bit rate. Software loads a 16-bit division value one byte at a time, through separate low-byte and high-byte write strobes. A separate high-speed select input also shapes the result. A fixed prescaler of `PRESCALE` reference cycles forms the base step. The division value counts those steps, so the tick period in reference cycles is `divisor * PRESCALE`. With the usual table values this gives the standard rates from 50 up to 115200 baud, where a divisor of 1 is the fastest normal rate.

When the high-speed select is high and bit 15 of the division value is set, the prescaler step shrinks to a quarter (`PRESCALE/4`) and only the low fifteen bits are used as the count. A value of 0x8001 then runs four times faster than a divisor of 1, which is 460800 baud. A value of 0x8002 runs twice as fast, which is 230400 baud. A count of zero, in either mode, halts the tick.

Internally a two-state controller holds the count. In HALT no ticks are produced. In RUN a down-counter steps on each prescaler step and fires on reaching zero. The transitions are:
- HALT→RUN on a reload with a nonzero count.
- RUN→HALT on a reload with a zero count.
- RUN→RUN on a reload or on a terminal count, which restarts the down-counter.

A reload is raised by any byte write or by any change of the high-speed select.

Top module: `baud_gen16`

## Requirements
- R1: `tick16` is high for exactly one reference cycle at a time, and in normal mode its period is `divisor * PRESCALE` reference cycles.
- R2: The division value takes bits 7:0 from a `div_lo_we` write and bits 15:8 from a `div_hi_we` write of `div_wdata`. Each write leaves the other byte unchanged.
- R3: With the default `PRESCALE` of 8, divisors 1, 2, 3, 6, 12, 96 and 2304 give tick periods of 8, 16, 24, 48, 96, 768 and 18432 cycles. These are the 115200 to 50 baud table rates.
- R4: With `speed_sel`=1 and divisor bit 15 = 1, the period is `divisor[14:0] * PRESCALE/4`. So 0x8001 gives 2 cycles (460800 baud) and 0x8002 gives 4 cycles (230400 baud).
- R5: With divisor bit 15 = 0, `speed_sel` has no effect on the period.
- R6: With `speed_sel`=0, a divisor with bit 15 set divides by the full 16-bit value, for example 0x8001 gives a period of 32769*PRESCALE cycles.
- R7: An effective count of zero produces no ticks. This means divisor 0, or 0x8000 with `speed_sel`=1.
- R8: A byte write or a `speed_sel` change sampled at edge k restarts the timing. The first new tick is high in the cycle after edge k+1+period.
- R9: If a restart lands on the edge where a tick was due, that tick is not produced.
- R10: While and right after reset, `tick16` is low and the divisor is zero (halted).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_lo_we | input | 1 | Write strobe for divisor bits 7:0 |
| div_hi_we | input | 1 | Write strobe for divisor bits 15:8 |
| div_wdata | input | 8 | Byte written by either strobe |
| speed_sel | input | 1 | High-speed select |
| tick16 | output | 1 | One-cycle enable at 16x the baud rate |

## Verification
The restart and the terminal count can meet on the same edge. The bench provokes this by locking onto a running tick train with divisor 2, then rewriting the low byte so that its reload edge coincides with the next due tick. It judges that no tick appears on that edge and that the next one arrives a full period later. A behavioural model that counts edges since each reload checks the same collision, and every other cycle, independently of the counter structure.

// File: rtl/baud_gen_pkg.sv
package baud_gen_pkg;
    typedef enum logic {
        ST_HALT = 1'b0,
        ST_RUN  = 1'b1
    } core_state_t;

    // Ratio between the normal and the high-speed prescaler step.
    localparam int HS_FACTOR = 4;
endpackage

// File: rtl/baud_div_latch.sv
module baud_div_latch #(
    parameter int BYTE_W = 8,
    parameter int DIV_W  = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lo_we,
    input  logic              hi_we,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              speed_in,
    output logic [DIV_W-1:0]  divisor,
    output logic              speed_q,
    output logic              reload
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            divisor <= '0;
            speed_q <= 1'b0;
            reload  <= 1'b0;
        end else begin
            if (lo_we) divisor[BYTE_W-1:0]     <= wdata;
            if (hi_we) divisor[DIV_W-1:BYTE_W] <= wdata;
            speed_q <= speed_in;
            reload  <= lo_we | hi_we | (speed_in != speed_q);
        end
    end

    AST_WRITE_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_we || hi_we) |=> reload); // R8
    AST_LO_BYTE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_we && !hi_we) |=> (divisor[BYTE_W-1:0] == $past(wdata)
                               && $stable(divisor[DIV_W-1:BYTE_W]))); // R2
endmodule

// File: rtl/baud_prescale.sv
module baud_prescale
    import baud_gen_pkg::*;
#(
    parameter int PRESCALE = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic reload,
    input  logic hs_mode,
    output logic base_tick
);
    localparam int HS_PRE = PRESCALE / HS_FACTOR;
    localparam int CNT_W  = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;

    logic [CNT_W-1:0] pre_cnt;
    logic [CNT_W-1:0] limit;

    assign limit     = hs_mode ? CNT_W'(HS_PRE - 1) : CNT_W'(PRESCALE - 1);
    assign base_tick = (pre_cnt == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   pre_cnt <= '0;
        else if (reload || base_tick) pre_cnt <= '0;
        else                          pre_cnt <= pre_cnt + 1'b1;
    end

    AST_BASE_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        (base_tick && !reload) |=> !base_tick); // R1
endmodule

// File: rtl/baud_div_core.sv
module baud_div_core
    import baud_gen_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reload,
    input  logic             base_tick,
    input  logic [DIV_W-1:0] eff_div,
    output logic             tick16
);
    core_state_t      state, state_n;
    logic [DIV_W-1:0] cnt, cnt_n;
    logic             tick_n;

    // State and count register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_HALT;
            cnt   <= '0;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
        end
    end

    // Next state, next count, next output.
    always_comb begin
        state_n = state;
        cnt_n   = cnt;
        tick_n  = 1'b0;
        if (reload) begin
            if (eff_div == '0) begin
                state_n = ST_HALT;
                cnt_n   = '0;
            end else begin
                state_n = ST_RUN;
                cnt_n   = eff_div - 1'b1;
            end
        end else begin
            unique case (state)
                ST_HALT: begin
                    cnt_n = '0;
                end
                ST_RUN: begin
                    if (base_tick) begin
                        if (cnt == '0) begin
                            tick_n = 1'b1;
                            cnt_n  = eff_div - 1'b1;
                        end else begin
                            cnt_n = cnt - 1'b1;
                        end
                    end
                end
                default: state_n = ST_HALT;
            endcase
        end
    end

    // Output register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tick16 <= 1'b0;
        else        tick16 <= tick_n;
    end

    AST_HALT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HALT) |-> !tick16); // R7
    AST_RELOAD_MUTES: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> !tick16); // R9
    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        tick16 |=> !tick16); // R1
endmodule

// File: rtl/baud_gen16.sv
module baud_gen16
    import baud_gen_pkg::*;
#(
    parameter int PRESCALE = 8,
    parameter int BYTE_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              div_lo_we,
    input  logic              div_hi_we,
    input  logic [BYTE_W-1:0] div_wdata,
    input  logic              speed_sel,
    output logic              tick16
);
    localparam int DIV_W = 2 * BYTE_W;

    logic [DIV_W-1:0] divisor;
    logic [DIV_W-1:0] eff_div;
    logic             speed_q;
    logic             reload;
    logic             hs_mode;
    logic             base_tick;

    baud_div_latch #(.BYTE_W(BYTE_W), .DIV_W(DIV_W)) u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .lo_we    (div_lo_we),
        .hi_we    (div_hi_we),
        .wdata    (div_wdata),
        .speed_in (speed_sel),
        .divisor  (divisor),
        .speed_q  (speed_q),
        .reload   (reload)
    );

    assign hs_mode = speed_q & divisor[DIV_W-1];
    assign eff_div = hs_mode ? {1'b0, divisor[DIV_W-2:0]} : divisor;

    baud_prescale #(.PRESCALE(PRESCALE)) u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .reload    (reload),
        .hs_mode   (hs_mode),
        .base_tick (base_tick)
    );

    baud_div_core #(.DIV_W(DIV_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .reload    (reload),
        .base_tick (base_tick),
        .eff_div   (eff_div),
        .tick16    (tick16)
    );

    AST_SPEED_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        !divisor[DIV_W-1] |-> (eff_div == divisor)); // R5
endmodule

// File: tb/test_baud_gen16.sv
`timescale 1ns/1ps
module test_baud_gen16;
    localparam int PRE = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       lo_we = 1'b0;
    logic       hi_we = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic       speed = 1'b0;
    logic       tick16;

    int  n_chk = 0;
    int  n_err = 0;
    bit  done  = 1'b0;
    bit  live  = 1'b0;

    always #2.5 clk = ~clk;

    baud_gen16 #(.PRESCALE(PRE)) i_baud_gen16 (
        .clk       (clk),
        .rst_n     (rst_n),
        .div_lo_we (lo_we),
        .div_hi_we (hi_we),
        .div_wdata (wdata),
        .speed_sel (speed),
        .tick16    (tick16)
    );

    // Behavioural reference: edges since last restart, modulo the period.
    int m_div, m_per, m_s, m_d, m_p;
    bit m_spd, m_pend, m_exp, m_hs;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_div = 0; m_spd = 0; m_per = 0; m_s = 0; m_pend = 0; m_exp = 0;
        end else begin
            if (m_pend) begin
                m_hs  = m_spd && (m_div >= 32768);
                m_d   = m_hs ? m_div - 32768 : m_div;
                m_p   = m_hs ? PRE / 4 : PRE;
                m_per = m_d * m_p;
                m_s   = 0;
                m_exp = 0;
            end else begin
                m_s   = m_s + 1;
                m_exp = (m_per != 0) && (m_s % m_per == 0);
            end
            m_pend = lo_we || hi_we || (speed != m_spd);
            if (lo_we) m_div = (m_div & 32'hFF00) | int'(wdata);
            if (hi_we) m_div = (m_div & 32'h00FF) | (int'(wdata) << 8);
            m_spd = speed;
        end
    end

    always @(negedge clk) begin
        if (live && !done) begin
            n_chk++;
            if (tick16 !== m_exp) begin
                n_err++;
                $display("FAIL R1/R8 per-cycle model: tick16=%0b expected=%0b at %0t", tick16, m_exp, $time);
            end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input bit hi, input logic [7:0] v, input bit spd);
        @(negedge clk);
        lo_we = !hi; hi_we = hi; wdata = v; speed = spd;
        @(negedge clk);
        lo_we = 1'b0; hi_we = 1'b0;
    endtask

    task automatic measure(input logic [15:0] d, input bit spd, input int per,
                           input int win, input string req);
        int cnt = 0;
        wr(1'b0, d[7:0], speed);
        wr(1'b1, d[15:8], spd);
        for (int i = 0; i < win; i++) begin
            @(negedge clk);
            if (tick16) cnt++;
        end
        check(req, cnt, (per == 0) ? 0 : (win - 1) / per);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R10 reset tick low", int'(tick16), 0);
        rst_n = 1'b1;
        live  = 1'b1;
        repeat (20) @(negedge clk);
        check("R10 halted after reset", int'(tick16), 0);

        // R3 table rates, normal mode
        measure(16'd1,    1'b0, 1 * PRE,    2 * 1 * PRE + 1,    "R3 div 1");
        measure(16'd2,    1'b0, 2 * PRE,    2 * 2 * PRE + 1,    "R3 div 2");
        measure(16'd3,    1'b0, 3 * PRE,    2 * 3 * PRE + 1,    "R3 div 3");
        measure(16'd6,    1'b0, 6 * PRE,    2 * 6 * PRE + 1,    "R3 div 6");
        measure(16'd12,   1'b0, 12 * PRE,   2 * 12 * PRE + 1,   "R3 div 12");
        measure(16'd96,   1'b0, 96 * PRE,   2 * 96 * PRE + 1,   "R3 div 96");
        measure(16'd2304, 1'b0, 2304 * PRE, 2 * 2304 * PRE + 1, "R2 R3 div 2304");
        // R4 high-speed encodings
        measure(16'h8001, 1'b1, PRE / 4,     8 * (PRE / 4) + 1, "R4 460800");
        measure(16'h8002, 1'b1, 2 * PRE / 4, 8 * (PRE / 4) + 1, "R4 230400");
        // R5 speed select ignored without bit 15
        measure(16'd12,   1'b1, 12 * PRE,   2 * 12 * PRE + 1,   "R5 div 12 speed high");
        // R6 bit 15 without speed select: full 16-bit divide, no tick in window
        measure(16'h8001, 1'b0, 32769 * PRE, 3000,              "R6 0x8001 normal");
        // R7 zero counts
        measure(16'h0000, 1'b0, 0, 2000, "R7 divisor zero");
        measure(16'h8000, 1'b1, 0, 2000, "R7 0x8000 high-speed");

        // R8 / R9: restart on the edge of a due tick
        wr(1'b0, 8'd2, 1'b0);
        wr(1'b1, 8'd0, 1'b0);
        begin
            int guard = 0;
            do begin
                @(negedge clk);
                guard++;
            end while (!tick16 && guard < 100);
            check("R8 tick train found", int'(guard < 100), 1);
        end
        repeat (14) @(negedge clk);
        lo_we = 1'b1; wdata = 8'd2;
        @(negedge clk);
        lo_we = 1'b0;
        @(negedge clk);
        check("R9 due tick suppressed", int'(tick16), 0);
        repeat (15) @(negedge clk);
        check("R8 no early tick", int'(tick16), 0);
        @(negedge clk);
        check("R8 first tick after restart", int'(tick16), 1);
        @(negedge clk);
        check("R1 single-cycle pulse", int'(tick16), 0);

        repeat (5) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule